// File: doc/BRIEF.md
# I2C Register-Pair Target Front End

This block is the serial side of a 16-bit I/O expander. It watches a two-wire bus with the system clock and recognises its own 7-bit device address. That address is set by three strap pins. Each strap can be tied low, tied high, or wired to the clock line or the data line of the bus. After an acknowledged address with a write direction, the first byte is a command that loads a register pointer. Further bytes in that transaction are written through a one-cycle strobe to a separate register bank. A read transaction streams bytes out of the bank, starting at the pointer.

The register space holds four pairs and one single register. Pair 0x00/0x01 is the input port and is read-only. Pair 0x02/0x03 is the output port, 0x04/0x05 is polarity inversion and 0x06/0x07 is direction. Register 0x08 is the bus-timeout control. Within one transaction, consecutive data bytes swap between the two halves of a pair rather than counting upward. A timeout monitor outside the block can force the block back to idle.

The data path to the bank has no back-pressure. A strobe is a single clock wide, and the bank must not stall it. Read data must be valid on `reg_rdata_i` in the same cycle that `reg_rd_o` is high. Write data and address are valid only while `reg_wr_o` is high. The open-drain pad is outside the block: `sda_lo_o` high means "pull SDA low".

Top module: `i2c_pair_slave`

## Requirements
- R1: A START followed by an address byte whose upper seven bits equal the strap-derived address gets an acknowledge, with SDA pulled low during the ninth clock. A mismatching address gets no acknowledge, and SDA is never driven until the next START. The 7-bit address is built as follows. Bit 6 is 1 when strap 2 follows a bus line. Bits 5:3 depend on which of straps 1 and 0 follow a bus line: neither gives 100, only strap 1 gives 010, both give 011, and only strap 0 gives 101. Bits 2:0 are 1 for each strap (2, 1, 0) tied high or to SDA.
- R2: Each strap is classified from what it has shown since reset. If it was never high, it is tied low. If it was never low, it is tied high. If it never differed from SCL, it is tied to SCL. Otherwise it is tied to SDA. Examples: all low gives 0x20; straps (low, SCL, SDA) give 0x19; straps (SDA, high, low) give 0x66.
- R3: In a write transaction, the command byte sets the pointer. A write that stops or restarts after the command leaves only the pointer changed. A read after a repeated START begins at that pointer.
- R4: Each data byte of a write is acknowledged. `reg_wr_o` pulses for one cycle at the falling SCL edge that ends the acknowledge clock, carrying the byte and the pointer.
- R5: After each data byte (written, or read and acknowledged by the master), a pointer below 0x08 flips its lowest bit. A pointer of 0x08 or above stays where it is.
- R6: A read sends bytes MSB first. `reg_rd_o` pulses once, at the SCL fall that starts each byte. Reading continues for as long as the master acknowledges. A master NACK releases SDA and ends the transfer.
- R7: Data bytes aimed at 0x00 or 0x01 are acknowledged but produce no write strobe.
- R8: A pointer above 0x08 reads as 0x00 and produces neither strobe.
- R9: `tmo_rst` high returns the block to idle and releases SDA on the next cycle. Later bytes are ignored until a new START.
- R10: After reset, SDA is released, both strobes are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_rst | input | 1 | Force-to-idle request from the timeout monitor |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| strap_i | input | 3 | Address strap pins, index 2 down to 0 |
| sda_lo_o | output | 1 | Pull the data line low |
| reg_rd_o | output | 1 | One-cycle read strobe to the register bank |
| reg_wr_o | output | 1 | One-cycle write strobe to the register bank |
| reg_addr_o | output | REG_AW | Register index (pointer) |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rdata_i | input | 8 | Read data from the bank, valid with reg_rd_o |

## Verification
A corrupted pointer appears at the ports within one byte time. It shows either as a write strobe with the wrong index, or as a read byte that disagrees with the model's copy of the bank. A mis-classified strap shows on the very first address byte, as a missing or unexpected acknowledge. A drive flag left set shows as SDA held low while the bus should be idle, and the bench looks for this on every clock. An unwanted strobe at 0x00/0x01 or above 0x08 is caught in the cycle it happens, because it does not match the expected-write queue.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;

  localparam int NUM_STRAPS = 3;
  localparam logic [7:0] REG_LAST     = 8'h08;
  localparam logic [7:0] REG_FIRST_WR = 8'h02;

  // strap classes: bit1 = follows a bus line, bit0 = contributes a one
  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_HIGH = 2'b01,
    STRAP_SCL  = 2'b10,
    STRAP_SDA  = 2'b11
  } strap_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_CMD, PH_CMD_ACK,
    PH_WR, PH_WR_ACK, PH_RD, PH_RD_ACK
  } phase_e;

  function automatic logic [6:0] strap_to_addr(input logic [1:0] c2,
                                               input logic [1:0] c1,
                                               input logic [1:0] c0);
    logic [2:0] grp;
    case ({c1[1], c0[1]})
      2'b00:   grp = 3'b100;
      2'b10:   grp = 3'b010;
      2'b11:   grp = 3'b011;
      default: grp = 3'b101;
    endcase
    return {c2[1], grp, c2[0], c1[0], c0[0]};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    chain[0] <= d_i;
    for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_strap_decoder.sv
module i2c_strap_decoder
  import i2c_pair_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STRAPS-1:0] strap_s,
  input  logic                  scl_s,
  output logic [6:0]            dev_addr_o
);
  logic [NUM_STRAPS-1:0][1:0] cls_v;

  generate
    for (genvar k = 0; k < NUM_STRAPS; k++) begin : g_strap
      logic   seen_hi, seen_lo, off_scl;
      strap_e cls;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          seen_hi <= 1'b0;
          seen_lo <= 1'b0;
          off_scl <= 1'b0;
        end else begin
          if (strap_s[k]) seen_hi <= 1'b1;
          else            seen_lo <= 1'b1;
          if (strap_s[k] != scl_s) off_scl <= 1'b1;
        end
      end

      always_comb begin
        if (!seen_hi)      cls = STRAP_LOW;
        else if (!seen_lo) cls = STRAP_HIGH;
        else if (!off_scl) cls = STRAP_SCL;
        else               cls = STRAP_SDA;
      end

      assign cls_v[k] = cls;
    end
  endgenerate

  assign dev_addr_o = strap_to_addr(cls_v[2], cls_v[1], cls_v[0]);
endmodule

// File: rtl/i2c_pair_slave.sv
module i2c_pair_slave
  import i2c_pair_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tmo_rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [NUM_STRAPS-1:0] strap_i,
  output logic                  sda_lo_o,
  output logic                  reg_rd_o,
  output logic                  reg_wr_o,
  output logic [REG_AW-1:0]     reg_addr_o,
  output logic [7:0]            reg_wdata_o,
  input  logic [7:0]            reg_rdata_i
);
  localparam int SW = NUM_STRAPS + 2;

  logic [SW-1:0] sync_q;
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [NUM_STRAPS-1:0] strap_s;
  logic [6:0] dev_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(SW)) u_sync (
    .clk(clk), .d_i({strap_i, sda_i, scl_i}), .q_o(sync_q));

  assign scl_s   = sync_q[0];
  assign sda_s   = sync_q[1];
  assign strap_s = sync_q[SW-1:2];

  i2c_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2c_strap_decoder u_strap (
    .clk(clk), .rst_n(rst_n), .strap_s(strap_s), .scl_s(scl_s),
    .dev_addr_o(dev_addr));

  phase_e     ph;
  logic [2:0] bitcnt;
  logic       byte_done, rw, mack, drv;
  logic [7:0] sh, ptr, ptr_tog, load_val;
  logic       ptr_ok, ptr_wr_ok, rd_fire, wr_fire;

  always_comb begin
    ptr_ok    = (ptr <= REG_LAST);
    ptr_wr_ok = ptr_ok && (ptr >= REG_FIRST_WR);
    ptr_tog   = (ptr < REG_LAST) ? (ptr ^ 8'h01) : ptr;
    load_val  = ptr_ok ? reg_rdata_i : 8'h00;
    rd_fire   = scl_fall && !tmo_rst &&
                ((ph == PH_ADDR_ACK && rw) || (ph == PH_RD_ACK && mack));
    wr_fire   = scl_fall && !tmo_rst && (ph == PH_WR_ACK);
  end

  assign reg_rd_o    = rd_fire && ptr_ok;
  assign reg_wr_o    = wr_fire && ptr_wr_ok;
  assign reg_addr_o  = ptr[REG_AW-1:0];
  assign reg_wdata_o = sh;
  assign sda_lo_o    = drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; bitcnt <= '0; byte_done <= 1'b0; sh <= '0;
      ptr <= '0; rw <= 1'b0; mack <= 1'b0; drv <= 1'b0;
    end else if (tmo_rst) begin
      ph <= PH_IDLE; drv <= 1'b0; byte_done <= 1'b0;
    end else if (start_ev) begin
      ph <= PH_ADDR; bitcnt <= '0; byte_done <= 1'b0; drv <= 1'b0;
    end else if (stop_ev) begin
      ph <= PH_IDLE; drv <= 1'b0; byte_done <= 1'b0;
    end else begin
      case (ph)
        PH_ADDR, PH_CMD, PH_WR: begin
          if (scl_rise) begin
            sh        <= {sh[6:0], sda_s};
            bitcnt    <= bitcnt + 3'd1;
            byte_done <= (bitcnt == 3'd7);
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            if (ph == PH_ADDR) begin
              if (sh[7:1] == dev_addr) begin
                drv <= 1'b1; rw <= sh[0]; ph <= PH_ADDR_ACK;
              end else begin
                ph <= PH_IDLE;
              end
            end else if (ph == PH_CMD) begin
              drv <= 1'b1; ptr <= sh; ph <= PH_CMD_ACK;
            end else begin
              drv <= 1'b1; ph <= PH_WR_ACK;
            end
          end
        end
        PH_ADDR_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            sh <= load_val; drv <= ~load_val[7]; ph <= PH_RD;
          end else begin
            drv <= 1'b0; ph <= PH_CMD;
          end
        end
        PH_CMD_ACK: if (scl_fall) begin
          drv <= 1'b0; ph <= PH_WR;
        end
        PH_WR_ACK: if (scl_fall) begin
          drv <= 1'b0; ptr <= ptr_tog; ph <= PH_WR;
        end
        PH_RD: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            drv <= 1'b0; bitcnt <= '0; ph <= PH_RD_ACK;
          end else begin
            sh <= {sh[6:0], 1'b0}; drv <= ~sh[6]; bitcnt <= bitcnt + 3'd1;
          end
        end
        PH_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
            if (!sda_s) ptr <= ptr_tog;
          end else if (scl_fall) begin
            if (mack) begin
              sh <= load_val; drv <= ~load_val[7]; ph <= PH_RD;
            end else begin
              ph <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_pair_slave_chk.sv
module i2c_pair_slave_chk #(
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmo_rst,
  input logic              sda_lo_o,
  input logic              reg_rd_o,
  input logic              reg_wr_o,
  input logic [REG_AW-1:0] reg_addr_o
);
  localparam logic [REG_AW-1:0] LO_WR = REG_AW'(2);
  localparam logic [REG_AW-1:0] HI_RG = REG_AW'(8);
  localparam logic [REG_AW-1:0] ONE   = REG_AW'(1);

  // R7 and R8: no write strobe outside 0x02..0x08
  assert_wr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (reg_addr_o >= LO_WR && reg_addr_o <= HI_RG));

  assert_pair_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && reg_addr_o < HI_RG) |=> (reg_addr_o == ($past(reg_addr_o) ^ ONE)));

  assert_tmo_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_rst |=> !sda_lo_o);

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));
endmodule

bind i2c_pair_slave i2c_pair_slave_chk #(.REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tmo_rst(tmo_rst), .sda_lo_o(sda_lo_o),
  .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o));

// File: tb/i2c_pair_slave_tb_top.sv
module i2c_pair_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, tmo_rst = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap;
  logic [1:0] cfg [3];
  logic sda_lo, rd, wr, sda_bus, quiet = 1'b1;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] bank [9];

  int checks = 0, errs = 0;
  logic [7:0]  mexp [9];
  logic [7:0]  mptr;
  logic [11:0] exp_wr [$];

  assign sda_bus = sda_m & ~sda_lo;

  always_comb
    for (int k = 0; k < 3; k++)
      case (cfg[k])
        2'd0:    strap[k] = 1'b0;
        2'd1:    strap[k] = 1'b1;
        2'd2:    strap[k] = scl_m;
        default: strap[k] = sda_bus;
      endcase

  i2c_pair_slave dut_i (
    .clk(clk), .rst_n(rst_n), .tmo_rst(tmo_rst), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .sda_lo_o(sda_lo), .reg_rd_o(rd), .reg_wr_o(wr),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata));

  // external register bank; unused slots return a non-zero pattern
  assign rdata = (addr <= 4'd8) ? bank[addr] : 8'hAA;
  always @(posedge clk) begin
    if (!rst_n) begin
      bank[0] <= 8'h5A; bank[1] <= 8'hC3; bank[2] <= 8'hFF; bank[3] <= 8'hFF;
      bank[4] <= 8'h00; bank[5] <= 8'h00; bank[6] <= 8'hFF; bank[7] <= 8'hFF;
      bank[8] <= 8'h01;
    end else if (wr && addr <= 4'd8) bank[addr] <= wdata;
  end

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr) begin
        logic [11:0] e;
        checks++;
        if (exp_wr.size() == 0) begin
          errs++;
          $display("FAIL R4/R7 unexpected write: actual=%0h:%0h expected=none", addr, wdata);
        end else begin
          e = exp_wr.pop_front();
          if ({addr, wdata} != e) begin
            errs++;
            $display("FAIL R4 write: actual=%0h:%0h expected=%0h:%0h", addr, wdata, e[11:8], e[7:0]);
          end
        end
      end
      if (quiet) begin
        checks++;
        if (sda_lo) begin
          errs++;
          $display("FAIL R1/R9 SDA driven while quiet: actual=1 expected=0");
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
    quiet = 1'b1;
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q); b = sda_bus;
    wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic recv(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~ack);
  endtask

  task automatic wr_begin(input logic [6:0] dev, input logic [7:0] cmd);
    logic a;
    quiet = 1'b0;
    bus_start();
    send({dev, 1'b0}, a); check("R1 address ack (write)", a, 1);
    send(cmd, a);         check("R3 command ack", a, 1);
    mptr = cmd;
  endtask

  task automatic wd(input string req, input logic [7:0] v);
    logic a;
    if (mptr >= 8'h02 && mptr <= 8'h08) begin
      exp_wr.push_back({mptr[3:0], v});
      mexp[mptr[3:0]] = v;
    end
    if (mptr < 8'h08) mptr = mptr ^ 8'h01;
    send(v, a);
    check(req, a, 1);
  endtask

  task automatic rd_begin(input logic [6:0] dev);
    logic a;
    quiet = 1'b0;
    bus_start();
    send({dev, 1'b1}, a); check("R1 address ack (read)", a, 1);
  endtask

  task automatic rd_byte(input string req, input logic last);
    logic [7:0] v, e;
    recv(v, ~last);
    e = (mptr <= 8'h08) ? mexp[mptr[3:0]] : 8'h00;
    check(req, v, e);
    if (!last && mptr < 8'h08) mptr = mptr ^ 8'h01;
  endtask

  task automatic do_reset(input logic [1:0] c2, input logic [1:0] c1, input logic [1:0] c0);
    rst_n = 1'b0; quiet = 1'b1;
    cfg[2] = c2; cfg[1] = c1; cfg[0] = c0;
    wclk(10);
    rst_n = 1'b1;
    mexp[0] = 8'h5A; mexp[1] = 8'hC3; mexp[2] = 8'hFF; mexp[3] = 8'hFF;
    mexp[4] = 8'h00; mexp[5] = 8'h00; mexp[6] = 8'hFF; mexp[7] = 8'hFF;
    mexp[8] = 8'h01; mptr = 8'h00;
    wclk(5);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic a;
    // configuration A: all straps low -> 0x20
    do_reset(2'd0, 2'd0, 2'd0);
    @(negedge clk);
    check("R10 sda released", sda_lo, 0);
    check("R10 read strobe low", rd, 0);
    check("R10 write strobe low", wr, 0);
    rd_begin(7'h20); rd_byte("R10 pointer starts at 0x00", 1'b1); bus_stop();

    wr_begin(7'h20, 8'h02);
    wd("R4 data ack", 8'h11); wd("R5 data ack", 8'h22); wd("R5 data ack", 8'h33);
    bus_stop();
    wr_begin(7'h20, 8'h06); wd("R4 data ack", 8'hF0); wd("R4 data ack", 8'h0F); bus_stop();

    wr_begin(7'h20, 8'h00); wd("R7 ignored byte still acked", 8'h99);
    wd("R7 ignored byte still acked", 8'h98); bus_stop();
    wr_begin(7'h20, 8'h00); rd_begin(7'h20);
    rd_byte("R3 read at pointer / R7 unchanged", 1'b0);
    rd_byte("R5 read flips to partner", 1'b0);
    rd_byte("R6 continued read", 1'b1); bus_stop();

    wr_begin(7'h20, 8'h02); rd_begin(7'h20);
    rd_byte("R6 read", 1'b0); rd_byte("R5 read", 1'b0);
    rd_byte("R5 read", 1'b0); rd_byte("R6 last read", 1'b1); bus_stop();
    @(negedge clk); check("R6 sda released after NACK", sda_lo, 0);

    wr_begin(7'h20, 8'h08); wd("R5 single reg", 8'h00); wd("R5 single reg", 8'h01); bus_stop();
    wr_begin(7'h20, 8'h08); rd_begin(7'h20);
    rd_byte("R5 0x08 stays", 1'b0); rd_byte("R5 0x08 stays", 1'b1); bus_stop();

    wr_begin(7'h20, 8'h0A); wd("R8 unused write acked", 8'h77); bus_stop();
    wr_begin(7'h20, 8'h0A); rd_begin(7'h20);
    rd_byte("R8 unused reads zero", 1'b0); rd_byte("R8 unused reads zero", 1'b1); bus_stop();

    // address mismatch: the bench keeps quiet set so any drive fails
    quiet = 1'b1;
    bus_start(); send({7'h21, 1'b0}, a); check("R1 mismatch NACK", a, 0);
    send(8'h02, a); check("R1 ignored after mismatch", a, 0); bus_stop();
    bus_start(); send({7'h40, 1'b1}, a); check("R1 mismatch NACK", a, 0); bus_stop();

    // timeout reset in the middle of a write
    quiet = 1'b0;
    bus_start(); send({7'h20, 1'b0}, a); check("R9 pre-timeout ack", a, 1);
    @(negedge clk); tmo_rst = 1'b1; @(negedge clk); tmo_rst = 1'b0;
    @(negedge clk); check("R9 sda released", sda_lo, 0);
    quiet = 1'b1;
    send(8'h02, a); check("R9 idle after timeout", a, 0); bus_stop();
    wr_begin(7'h20, 8'h06); rd_begin(7'h20); rd_byte("R9 normal after timeout", 1'b1); bus_stop();

    // configuration B: straps (low, SCL, SDA) -> 0x19
    do_reset(2'd0, 2'd2, 2'd3);
    wr_begin(7'h19, 8'h04); wd("R2 data ack", 8'hA5); bus_stop();
    wr_begin(7'h19, 8'h04); rd_begin(7'h19);
    rd_byte("R2 read", 1'b0); rd_byte("R2 read", 1'b1); bus_stop();
    quiet = 1'b1;
    bus_start(); send({7'h20, 1'b0}, a); check("R2 old address NACK", a, 0); bus_stop();

    // configuration C: straps (SDA, high, low) -> 0x66
    do_reset(2'd3, 2'd1, 2'd0);
    rd_begin(7'h66); rd_byte("R2 read", 1'b1); bus_stop();

    wclk(5);
    check("R4 all expected writes seen", exp_wr.size(), 0);
    summary();
    $finish;
  end
endmodule